// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This unit adds or subtracts two 32-bit binary floating-point operands. Each word holds a sign in bit 31, an 8-bit exponent biased by 127 in bits 30:23, and a 23-bit fraction in bits 22:0. A select input turns the operation into a subtraction by flipping the sign of the second operand before it is unpacked. The operand with the smaller exponent is aligned to the larger one. Both significands are then summed as signed two's-complement values. The signed sum is turned back into sign and magnitude, renormalized, rounded to nearest-even and packed again.

The datapath has two register stages. A request presented with `in_valid` high produces its result with `out_valid` high two clock edges later. One request can be accepted on every cycle. Zero, infinity and denormal encodings are handled. An overflowing result becomes a signed infinity. Any NaN result is given as a single canonical quiet NaN.

Top module: `fp32_addsub`

## Requirements
- R1: For normal operands, `result` is the sum of `opa` and `opb`, rounded to the nearest representable single-precision value, with ties going to the even significand.
- R2: When `sub` is 1, `result` is `opa` minus `opb`. For example, 1.0 minus -1.0 gives 0x40000000.
- R3: When the operands have opposite effective signs, the result takes the sign of the larger magnitude. For example, 40.0 minus 80.0 gives -40.0 = 0xC2200000, with the sign bit set.
- R4: An exactly zero sum is +0 (0x00000000). The one exception is when both effective operands are -0, in which case the result is 0x80000000.
- R5: A carry out of the significand sum shifts the result right once and raises the exponent by one. For example, 1.5 + 1.5 gives 0x40400000.
- R6: An exponent field of 0 with a nonzero fraction is read as 0.fraction x 2^-126. Results below 2^-126 are produced as denormals. For example, 0x00800000 minus 0x00000001 gives 0x007FFFFF, and 0x00400000 + 0x00400000 gives 0x00800000.
- R7: Rounding keeps the bits shifted out during alignment. An exact half-way case rounds to an even fraction. For example, 0x3F800000 + 0x33800000 gives 0x3F800000, and 0x3F800001 + 0x33800000 gives 0x3F800002.
- R8: A finite sum whose exponent would reach 255 becomes infinity with the sum's sign: 0x7F800000 or 0xFF800000. A finite-operand result never has exponent 255 together with a nonzero fraction.
- R9: An infinite operand (exponent 255, fraction 0) passes through with its effective sign. Two infinities of opposite effective sign, or any NaN operand, give 0x7FC00000.
- R10: `out_valid` rises exactly two rising clock edges after an accepted `in_valid`. It is low when no request was accepted two edges earlier, and it is low after a synchronous reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present on opa, opb, sub |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| sub | input | 1 | 1 selects opa minus opb, 0 selects opa plus opb |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 32 | Rounded sum or difference |

## Verification
Several hundred random normal operand pairs, with random signs and a random select, are checked against a double-precision model of the sum rounded to 24 bits. This separates correct alignment and sticky handling from errors that only appear at particular exponent gaps. Directed operand pairs then target the cases random values almost never hit. Equal-magnitude cancellation and -0 plus -0 test the zero sign. 40 minus 80 tests the conversion of a negative two's-complement sum back to a magnitude. The exact half-way pairs distinguish round-to-even from truncation or rounding half away from zero. Denormal pairs on both sides of 2^-126 show whether the renormalizing shift stops at the minimum exponent. Largest-value pairs and infinity operands exercise the overflow path and the special-case path.

// File: rtl/fp32_pkg.sv
package fp32_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;        // significand with hidden bit
  localparam int GRS_W  = 3;                 // guard, round, sticky
  localparam int WIDE_W = MANT_W + GRS_W;    // aligned significand width
  localparam int SUM_W  = WIDE_W + 2;        // carry plus two's-complement sign
  localparam int EXPI_W = EXP_W + 2;         // internal exponent with headroom
  localparam logic [EXPI_W-1:0] EXP_MAX = EXPI_W'((1 << EXP_W) - 1);

  typedef struct packed {
    logic              sign;
    logic [EXPI_W-1:0] exp;    // effective exponent, 1 for denormals
    logic [MANT_W-1:0] mant;
    logic              is_inf;
    logic              is_nan;
  } fp_parts_t;
endpackage

// File: rtl/fp32_unpack.sv
module fp32_unpack
  import fp32_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              flip,
  output fp_parts_t         parts
);
  logic [EXP_W-1:0]  efield;
  logic [FRAC_W-1:0] ffield;
  logic              e_zero, e_ones;

  always_comb begin
    efield = word[WORD_W-2 -: EXP_W];
    ffield = word[FRAC_W-1:0];
    e_zero = (efield == '0);
    e_ones = (efield == '1);
    parts.sign   = word[WORD_W-1] ^ flip;
    parts.exp    = e_zero ? EXPI_W'(1) : EXPI_W'(efield);
    parts.mant   = {~e_zero, ffield};
    parts.is_inf = e_ones && (ffield == '0);
    parts.is_nan = e_ones && (ffield != '0);
  end
endmodule

// File: rtl/fp32_align_sum.sv
module fp32_align_sum
  import fp32_pkg::*;
(
  input  logic              sign_a,
  input  logic [EXPI_W-1:0] exp_a,
  input  logic [MANT_W-1:0] mant_a,
  input  logic              sign_b,
  input  logic [EXPI_W-1:0] exp_b,
  input  logic [MANT_W-1:0] mant_b,
  output logic              sum_sign,
  output logic [WIDE_W:0]   sum_mag,
  output logic [EXPI_W-1:0] sum_exp
);
  logic              a_big, big_s, sml_s;
  logic [EXPI_W-1:0] gap;
  logic [WIDE_W-1:0] big_w, sml_w, sml_sh, lost_mask;
  logic              sticky;
  logic [SUM_W-1:0]  tc_big, tc_sml, tc_sum, tc_mag;

  always_comb begin
    a_big   = (exp_a >= exp_b);
    big_s   = a_big ? sign_a : sign_b;
    sml_s   = a_big ? sign_b : sign_a;
    sum_exp = a_big ? exp_a : exp_b;
    gap     = a_big ? (exp_a - exp_b) : (exp_b - exp_a);
    big_w   = {(a_big ? mant_a : mant_b), {GRS_W{1'b0}}};
    sml_w   = {(a_big ? mant_b : mant_a), {GRS_W{1'b0}}};
    if (gap >= EXPI_W'(WIDE_W)) begin
      sml_sh    = '0;
      lost_mask = '1;
    end else begin
      sml_sh    = sml_w >> gap;
      lost_mask = ~({WIDE_W{1'b1}} << gap);
    end
    sticky = |(sml_w & lost_mask);
    sml_sh[0] = sml_sh[0] | sticky;
    // signed significands in two's complement
    tc_big = big_s ? -{2'b00, big_w}  : {2'b00, big_w};
    tc_sml = sml_s ? -{2'b00, sml_sh} : {2'b00, sml_sh};
    tc_sum = tc_big + tc_sml;
    // back to sign and magnitude
    tc_mag   = tc_sum[SUM_W-1] ? -tc_sum : tc_sum;
    sum_mag  = tc_mag[WIDE_W:0];
    sum_sign = (tc_sum == '0) ? (sign_a & sign_b) : tc_sum[SUM_W-1];
  end
endmodule

// File: rtl/fp32_norm_round.sv
module fp32_norm_round
  import fp32_pkg::*;
(
  input  logic              sign,
  input  logic [WIDE_W:0]   mag,
  input  logic [EXPI_W-1:0] exp,
  output logic [WORD_W-1:0] word
);
  logic [EXPI_W-1:0] lz, lim, shamt, e1, e2;
  logic              found;
  logic [WIDE_W-1:0] m1;
  logic [MANT_W-1:0] keep, mant;
  logic [MANT_W:0]   rnd;
  logic              rnd_up;

  always_comb begin
    lz = EXPI_W'(WIDE_W);
    found = 1'b0;
    for (int i = WIDE_W - 1; i >= 0; i--) begin
      if (!found && mag[i]) begin
        lz = EXPI_W'(WIDE_W - 1 - i);
        found = 1'b1;
      end
    end
    lim   = exp - EXPI_W'(1);
    shamt = (lz < lim) ? lz : lim;
    if (mag[WIDE_W]) begin
      m1 = {mag[WIDE_W:2], mag[1] | mag[0]};
      e1 = exp + EXPI_W'(1);
    end else begin
      m1 = mag[WIDE_W-1:0] << shamt;
      e1 = exp - shamt;
    end
    keep   = m1[WIDE_W-1:GRS_W];
    rnd_up = m1[2] & (m1[1] | m1[0] | keep[0]);
    rnd    = {1'b0, keep} + (MANT_W+1)'(rnd_up);
    if (rnd[MANT_W]) begin
      mant = rnd[MANT_W:1];
      e2   = e1 + EXPI_W'(1);
    end else begin
      mant = rnd[MANT_W-1:0];
      e2   = e1;
    end
    if (mant[MANT_W-1] && e2 >= EXP_MAX)
      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (mant[MANT_W-1])
      word = {sign, e2[EXP_W-1:0], mant[FRAC_W-1:0]};
    else
      word = {sign, {EXP_W{1'b0}}, mant[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
  import fp32_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              sub,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [1:0][WORD_W-1:0] op_words;
  logic [1:0]             op_flip;
  fp_parts_t              parts [2];

  assign op_words = {opb, opa};
  assign op_flip  = {sub, 1'b0};

  for (genvar k = 0; k < 2; k++) begin : g_unpack
    fp32_unpack u_unpack (.word(op_words[k]), .flip(op_flip[k]), .parts(parts[k]));
  end

  logic              c_sign;
  logic [WIDE_W:0]   c_mag;
  logic [EXPI_W-1:0] c_exp;

  fp32_align_sum u_sum (
    .sign_a(parts[0].sign), .exp_a(parts[0].exp), .mant_a(parts[0].mant),
    .sign_b(parts[1].sign), .exp_b(parts[1].exp), .mant_b(parts[1].mant),
    .sum_sign(c_sign), .sum_mag(c_mag), .sum_exp(c_exp)
  );

  logic              c_special;
  logic [WORD_W-1:0] c_spec_word;

  always_comb begin
    c_special   = 1'b1;
    c_spec_word = QNAN;
    if (parts[0].is_nan || parts[1].is_nan ||
        (parts[0].is_inf && parts[1].is_inf && (parts[0].sign != parts[1].sign)))
      c_spec_word = QNAN;
    else if (parts[0].is_inf)
      c_spec_word = {parts[0].sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (parts[1].is_inf)
      c_spec_word = {parts[1].sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      c_special = 1'b0;
  end

  // stage 1 register
  logic              s1_valid, s1_sign, s1_special;
  logic [WIDE_W:0]   s1_mag;
  logic [EXPI_W-1:0] s1_exp;
  logic [WORD_W-1:0] s1_spec_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
    s1_sign      <= c_sign;
    s1_mag       <= c_mag;
    s1_exp       <= c_exp;
    s1_special   <= c_special;
    s1_spec_word <= c_spec_word;
  end

  logic [WORD_W-1:0] n_word;

  fp32_norm_round u_norm (.sign(s1_sign), .mag(s1_mag), .exp(s1_exp), .word(n_word));

  // stage 2 register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s1_valid;
      result    <= s1_special ? s1_spec_word : n_word;
    end
  end

  assert_stage1_valid_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);

  assert_stage2_valid_R10: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);

  assert_zero_sum_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_special && s1_mag == '0) |=> (result[WORD_W-2:0] == '0));

  assert_finite_not_nan_R8: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_special) |=>
      (result[WORD_W-2 -: EXP_W] != '1 || result[FRAC_W-1:0] == '0));

  assert_sign_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_special && s1_mag != '0) |=> (result[WORD_W-1] == $past(s1_sign)));
endmodule

// File: tb/tb_fp32_addsub.sv
module tb_fp32_addsub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        sub = 1'b0;
  logic        out_valid;
  logic [31:0] result;

  always #5 clk = ~clk;

  fp32_addsub dut (.clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
                   .sub(sub), .out_valid(out_valid), .result(result));

  int checks = 0, errors = 0, cycle = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          when_q[$];

  always @(posedge clk) cycle <= cycle + 1;

  // model: float bits -> double, for normal operands only
  function automatic real f2r(input logic [31:0] f);
    logic [63:0] d;
    d = {f[31], 11'(f[30:23]) + 11'd896, f[22:0], 29'd0};
    return $bitstoreal(d);
  endfunction

  // double -> float with round to nearest even (normal range)
  function automatic logic [31:0] r2f(input real r);
    logic [63:0] d;
    logic [24:0] m;
    logic [28:0] rem;
    int          ef;
    d = $realtobits(r);
    if (d[62:0] == '0) return {d[63], 31'd0};
    ef  = int'(d[62:52]) - 896;
    m   = {2'b01, d[51:29]};
    rem = d[28:0];
    if (rem > 29'h10000000 || (rem == 29'h10000000 && m[0])) m = m + 25'd1;
    if (m[24]) begin m = m >> 1; ef = ef + 1; end
    if (ef >= 255) return {d[63], 8'hFF, 23'd0};
    return {d[63], 8'(ef), m[22:0]};
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s,
                      input logic [31:0] expv, input string tag);
    @(negedge clk);
    in_valid = 1'b1; opa = a; opb = b; sub = s;
    exp_q.push_back(expv); tag_q.push_back(tag); when_q.push_back(cycle + 2);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected out_valid, actual result=%h expected no output", result);
      end else begin
        logic [31:0] e;
        string t;
        int w;
        e = exp_q.pop_front(); t = tag_q.pop_front(); w = when_q.pop_front();
        if (result !== e) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", t, result, e);
        end
        checks++;
        if (cycle != w) begin
          errors++;
          $display("FAIL R10: result at cycle %0d expected cycle %0d", cycle, w);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: out_valid in reset actual=%b expected=0", out_valid);
    end
    rst = 1'b0;
    idle(2);
    // directed cases
    send(32'h42200000, 32'h42A00000, 1'b1, 32'hC2200000, "R3");
    send(32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, "R2");
    send(32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, "R5");
    send(32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, "R4");
    send(32'h80000000, 32'h80000000, 1'b0, 32'h80000000, "R4");
    send(32'h80000000, 32'h00000000, 1'b1, 32'h80000000, "R4");
    send(32'h00000001, 32'h00000001, 1'b0, 32'h00000002, "R6");
    send(32'h00400000, 32'h00400000, 1'b0, 32'h00800000, "R6");
    send(32'h00800000, 32'h00000001, 1'b1, 32'h007FFFFF, "R6");
    send(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, "R7");
    send(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, "R7");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, "R8");
    send(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, "R8");
    send(32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, "R9");
    send(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, "R9");
    send(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, "R9");
    send(32'h7FC00001, 32'h3F800000, 1'b0, 32'h7FC00000, "R9");
    idle(4);
    // random normal operands, R1 against double-precision model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b, ex;
      logic        s;
      real         ra, rb;
      a  = {1'($urandom), 8'(30 + $urandom % 191), 23'($urandom)};
      b  = {1'($urandom), 8'(30 + $urandom % 191), 23'($urandom)};
      if (n % 4 == 0) b[30:23] = a[30:23] - 8'($urandom % 3);
      s  = 1'($urandom);
      ra = f2r(a); rb = f2r(b);
      ex = r2f(s ? (ra - rb) : (ra + rb));
      send(a, b, s, ex, s ? "R2" : "R1");
      if (n % 37 == 0) idle(1 + n % 3);
    end
    idle(6);
    // R10: no output once the queue is drained
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || exp_q.size() != 0) begin
        errors++;
        $display("FAIL R10: idle out_valid actual=%b expected=0 pending=%0d", out_valid, exp_q.size());
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule